// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status words for a small multi-core SoC. A register bus master reaches it through a 4 KiB byte-addressed window. Every access moves one whole word, and the word index comes from the upper ten address bits. The lower 2 KiB of the window is ordinary read/write storage of 512 words. A few of those words load identification constants at reset, and three of them always read back with two fixed high bits set.

One dedicated word near the top of the window acts as a power-control register. It stores whatever is written to it. When a write carries one of a few small command values, the block also emits a one-cycle request pulse: either a system reset request or a system shutdown request. The block only produces these pulses. Carrying out the reset or power-off belongs to logic outside it.

Top module: `sysctl_regfile`

## Requirements
- R1: The word index is taken from address bits 11:2 and address bits 1:0 are ignored, so an unaligned address reaches the same word as the aligned one.
- R2: Byte offsets 0x000 to 0x7FC map to 512 read/write words. `req_ready` is always high. A read accepted at one clock edge presents its data on `rsp_rdata` with `rsp_valid` high after the next edge.
- R3: On reset, the words at byte offsets 0x100, 0x104, 0x108 and 0x10C hold 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121. All other storage words and the power-control word hold zero.
- R4: A read of byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000, so bits 29 and 28 read as 1. Writes to these offsets store the data unchanged.
- R5: The word at byte offset 0xF00 is a power-control register that stores any written value and reads it back unmodified.
- R6: A write of 1 or 2 to offset 0xF00 raises `reset_req` for exactly the one cycle after the write edge.
- R7: A write of 3 to offset 0xF00 raises `shutdown_req` for exactly the one cycle after the write edge. Any other value raises no request. `reset_req` and `shutdown_req` are never high together.
- R8: Offsets 0x800 to 0xEFC and 0xF04 to 0xFFC read as zero. Writes to them change no register, including the storage words that share their lower address bits.
- R9: A write produces no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request acceptance (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
The bench goes after the window edges: 0x7FC against 0x800, and 0xF00 against its neighbours. A decoder that folded the upper half onto the array would corrupt low words or return stale data. It writes every power-control command value and its neighbours 0 and 4. A design with an off-by-one command decode would pulse for the wrong value, and one with sticky pulses would hold the request line high for more than one cycle. It writes values with bits 29:28 clear to the forced-bit offsets and reads them back, which catches a mask that is stored instead of applied on read, and a mask applied at the wrong offset. A seeded random mix of reads and writes is then checked against a bench model of all 513 live words.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    parameter int ADDR_W   = 12;
    parameter int DATA_W   = 32;
    parameter int WORDS    = 512;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int IDX_W   = $clog2(WORDS);

    localparam logic [WIDX_W-1:0] PWR_WIDX  = WIDX_W'(12'hF00 >> 2);
    localparam logic [DATA_W-1:0] STAT_MASK = 32'h3000_0000;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_RESET = 2'd1,
        CMD_HALT  = 2'd2
    } pwr_cmd_e;

    typedef struct packed {
        logic              in_array;
        logic              is_power;
        logic              is_status;
        logic [IDX_W-1:0]  index;
    } dec_t;

    function automatic logic is_status_word(input logic [WIDX_W-1:0] w);
        return (w == WIDX_W'(10'h040)) || (w == WIDX_W'(10'h042)) ||
               (w == WIDX_W'(10'h043));
    endfunction

    function automatic logic [DATA_W-1:0] reset_word(input int idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction

    function automatic pwr_cmd_e decode_cmd(input logic [DATA_W-1:0] d);
        if (d == 32'd1 || d == 32'd2) return CMD_RESET;
        if (d == 32'd3)               return CMD_HALT;
        return CMD_NONE;
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [WIDX_W-1:0] widx;
    logic [1:0]        unused_lsb;

    assign widx       = addr[ADDR_W-1:2];
    assign unused_lsb = addr[1:0];

    always_comb begin
        dec.in_array  = (widx < WIDX_W'(WORDS));
        dec.is_power  = (widx == PWR_WIDX);
        dec.is_status = dec.in_array && is_status_word(widx);
        dec.index     = widx[IDX_W-1:0];
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= reset_word(i);
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rword = mem[idx];
endmodule

// File: rtl/sysctl_power.sv
module sysctl_power
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              reset_req,
    output logic              shutdown_req
);
    pwr_cmd_e cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            cmd_q <= CMD_NONE;
        end else begin
            cmd_q <= we ? decode_cmd(wdata) : CMD_NONE;
            if (we) value <= wdata;
        end
    end

    assign reset_req    = (cmd_q == CMD_RESET);
    assign shutdown_req = (cmd_q == CMD_HALT);

    assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(reset_req && shutdown_req));
    assert_reset_cause_R6: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (value == 32'd1 || value == 32'd2));
    assert_halt_cause_R7: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> (value == 32'd3));
    assert_reset_single_R6: assert property (@(posedge clk) disable iff (rst)
        (reset_req && !$past(we)) |=> !reset_req);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              reset_req,
    output logic              shutdown_req
);
    dec_t              dec;
    logic              acc_wr, acc_rd;
    logic [DATA_W-1:0] arr_word, pwr_word, rd_next;

    assign req_ready = 1'b1;
    assign acc_wr    = req_valid && req_write;
    assign acc_rd    = req_valid && !req_write;

    sysctl_decode u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    sysctl_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (acc_wr && dec.in_array),
        .idx   (dec.index),
        .wdata (req_wdata),
        .rword (arr_word)
    );

    sysctl_power u_pwr (
        .clk          (clk),
        .rst          (rst),
        .we           (acc_wr && dec.is_power),
        .wdata        (req_wdata),
        .value        (pwr_word),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req)
    );

    always_comb begin
        if (dec.in_array)
            rd_next = arr_word | (dec.is_status ? STAT_MASK : '0);
        else if (dec.is_power)
            rd_next = pwr_word;
        else
            rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_rd;
            if (acc_rd) rsp_rdata <= rd_next;
        end
    end

    assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));
    assert_no_rsp_on_write_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid);
    assert_status_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && dec.is_status) |=> (rsp_rdata[29:28] == 2'b11));
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && !dec.in_array && !dec.is_power) |=> (rsp_rdata == '0));
endmodule

// File: tb/test_sysctl_regfile.sv
module test_sysctl_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_ready;
    logic [11:0] req_addr;
    logic [31:0] req_wdata, rsp_rdata;
    logic        rsp_valid, reset_req, shutdown_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [31:0] model [512];
    logic [31:0] model_pwr;

    always #2 clk = ~clk;

    sysctl_regfile i_sysctl_regfile (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .reset_req(reset_req), .shutdown_req(shutdown_req)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [9:0] w;
        w = a[11:2];
        if (!a[11]) begin
            if (w == 10'h040 || w == 10'h042 || w == 10'h043)
                return model[w[8:0]] | 32'h3000_0000;
            return model[w[8:0]];
        end
        if (w == 10'h3C0) return model_pwr;
        return 32'h0;
    endfunction

    function automatic string region(input logic [11:0] a);
        if (!a[11]) return "R2/R4";
        if (a[11:2] == 10'h3C0) return "R5";
        return "R8";
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bit is_pwr;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        is_pwr = (a[11:2] == 10'h3C0);
        if (!a[11]) model[a[10:2]] = d;
        else if (is_pwr) model_pwr = d;
        chk("R6 reset_req after write", {31'b0, reset_req},
            {31'b0, is_pwr && (d == 32'd1 || d == 32'd2)});
        chk("R7 shutdown_req after write", {31'b0, shutdown_req},
            {31'b0, is_pwr && (d == 32'd3)});
        chk("R9 no rsp_valid on write", {31'b0, rsp_valid}, 32'h0);
    endtask

    task automatic rd(input logic [11:0] a, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({rq, " rsp_valid"}, {31'b0, rsp_valid}, 32'h1);
        chk({rq, " read data"}, rsp_rdata, exp_read(a));
    endtask

    task automatic idle_pulse_check(input string rq);
        @(negedge clk);
        chk({rq, " pulse lasts one cycle"}, {30'b0, reset_req, shutdown_req}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < 512; i++) model[i] = 32'h0;
        model[9'h040] = 32'h05F2_0121; model[9'h041] = 32'h0000_0002;
        model[9'h042] = 32'h05F3_0121; model[9'h043] = 32'h05F4_0121;
        model_pwr = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R3 outputs idle after reset", {29'b0, rsp_valid, reset_req, shutdown_req}, 32'h0);
        chk("R2 req_ready high", {31'b0, req_ready}, 32'h1);

        // R3 identification defaults (R4 mask applies at 0x100/0x108/0x10C)
        rd(12'h100, "R3");
        chk("R3 id word 0x100", rsp_rdata, 32'h35F2_0121);
        rd(12'h104, "R3");
        chk("R3 id word 0x104", rsp_rdata, 32'h0000_0002);
        rd(12'h108, "R3");
        rd(12'h10C, "R3");
        rd(12'h000, "R3");
        rd(12'h7FC, "R3");
        rd(12'hF00, "R3 power word reset");

        // R1 unaligned access
        wr(12'h107, 32'h1234_5678);
        rd(12'h104, "R1");
        chk("R1 unaligned write lands on 0x104", rsp_rdata, 32'h1234_5678);
        rd(12'h106, "R1");

        // R4 forced status bits
        wr(12'h100, 32'h0);
        rd(12'h100, "R4");
        chk("R4 zero stored reads mask", rsp_rdata, 32'h3000_0000);
        wr(12'h10C, 32'hCFFF_FFFF);
        rd(12'h10C, "R4");
        wr(12'h108, 32'h0000_00A5);
        rd(12'h108, "R4");
        wr(12'h10A, 32'h1);
        rd(12'h104, "R4 neighbour 0x104 unforced");

        // R6 / R7 power commands
        wr(12'hF00, 32'd1); idle_pulse_check("R6");
        wr(12'hF00, 32'd2); idle_pulse_check("R6");
        wr(12'hF00, 32'd3); idle_pulse_check("R7");
        wr(12'hF00, 32'd4); idle_pulse_check("R7");
        wr(12'hF00, 32'd0); idle_pulse_check("R7");
        wr(12'hF03, 32'd3); idle_pulse_check("R7 unaligned");
        wr(12'hF00, 32'h0000_0103); idle_pulse_check("R7");
        wr(12'hF00, 32'hDEAD_BEEF);
        rd(12'hF00, "R5");
        chk("R5 power word readback", rsp_rdata, 32'hDEAD_BEEF);
        wr(12'hF00, 32'd2);
        rd(12'hF00, "R5 command value stored");

        // R8 unmapped region
        wr(12'h000, 32'hA5A5_0001);
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, "R8");
        rd(12'h000, "R8 no alias into array");
        chk("R8 array word 0 kept", rsp_rdata, 32'hA5A5_0001);
        wr(12'hF04, 32'd3);
        rd(12'hF04, "R8");
        wr(12'hEFC, 32'd1);
        rd(12'hFFC, "R8");
        rd(12'hF00, "R8 power word kept");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            int sel;
            sel = $urandom % 8;
            case (sel)
                0, 1, 2, 3: a = {1'b0, 11'($urandom)};
                4: a = {10'h040 + 10'(($urandom % 2) * 2 + (($urandom % 2) ? 1 : 0)), 2'($urandom)};
                5: a = {10'h3C0, 2'($urandom)};
                6: a = {1'b1, 11'($urandom)};
                default: a = {8'h10, 2'($urandom), 2'($urandom)};
            endcase
            d = (($urandom % 3) == 0) ? ($urandom % 5) : $urandom;
            if ($urandom % 2) wr(a, d);
            else rd(a, region(a));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule